// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Arbiter

The arbiter gathers a vector of interrupt request flags, each paired with a programmable 3-bit priority, together with five trap requests whose ranking is fixed. Flags and traps are captured on one clock edge. On the next edge the captured flags are combined with the priority fields as they stand then. That second stage publishes a request bus with one bit per priority level, and it picks a single winner.

A combinational gate compares the winner with the current CPU priority. It also applies the global enable and the nesting rule, and raises a take-exception strobe. The strobe carries a vector slot index, the winning source number and the priority the CPU should adopt. The CPU is expected to raise its priority to that value on the edge where the strobe is seen. Once it has, the same request no longer wins.

Loading the program counter, pushing the stack and clearing flags are left to the surrounding core. A flag input stays high until software clears it. Acknowledging an exception does not clear it.

Top module: `irq_arb`

## Requirements
- R1: A flag present at one clock edge is combined with the priority field present at the next edge, so a priority change made between those two edges is the one that counts; outputs reflect a flag two edges after it appears.
- R2: Bit n of `irq_bus_o` is 1 exactly when at least one captured flag has priority field n.
- R3: `take_o` stays low when the winning level (8 for a trap, otherwise 0 to 7) is lower than or equal to `cpu_prio_i`.
- R4: With the global enable clear, a winner at levels 0 to 6 does not raise `take_o`, while `irq_bus_o`, `new_prio_o` and `vec_o` keep tracking the pending requests.
- R5: A level-7 winner and any trap ignore both the global enable and the nesting rule; they are limited only by R3.
- R6: With `nest_en_i` low and `busy_i` high, a winner at levels 0 to 6 does not raise `take_o`; with `nest_en_i` high, a winner above `cpu_prio_i` does.
- R7: Trap bit 0 (oscillator fail) ranks over bits 1 to 4 in index order and above every interrupt; trap bit k selects vector slot k+1, and interrupt level L selects slot 15-L; slots 6 and 7 are never produced.
- R8: Among captured flags sharing the highest level, the lowest-numbered source wins and is reported on `src_o`.
- R9: `new_prio_o` equals the winning level, 8 for a trap, and 0 with nothing pending (with `vec_o` then 15).
- R10: The global enable is 0 after reset and changes only on a cycle with `gie_we_i` high, taking `gie_d_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_i | input | NUM_SRC | Interrupt request flags, held by software |
| prio_i | input | NUM_SRC*3 | Priority field per source, source s in bits [3s+2:3s] |
| trap_i | input | NUM_TRAP | Trap requests, bit 0 ranked highest |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_d_i | input | 1 | Value written to the global enable |
| nest_en_i | input | 1 | Allow levels 0 to 6 to nest over a running handler |
| busy_i | input | 1 | CPU is inside a handler |
| cpu_prio_i | input | 4 | Current CPU priority, 0 to 8 |
| irq_bus_o | output | 8 | One bit per level with a pending interrupt |
| take_o | output | 1 | Start an exception sequence now |
| vec_o | output | 4 | Vector slot of the winner |
| src_o | output | 3 | Winning interrupt source number |
| new_prio_o | output | 4 | Priority the CPU adopts on `take_o` |

## Verification
Two functions can meet in one cycle. A trap or level-7 request can win while the enable or nesting gate is shut, and a priority field can change in the same cycle that its flag is captured. The bench provokes both with random traps, enable writes and priority rewrites on every cycle, plus directed sequences that rewrite a field between the two capture edges. A behavioural model judges each cycle. Its CPU raises its priority on every strobe and sometimes returns to level 0, so the model also follows repeated nested entries.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LEVELS    = 8;
  localparam int PRIO_W    = 3;
  localparam int LVL_W     = PRIO_W + 1;
  localparam int VEC_W     = 4;
  localparam int TRAP_LVL  = LEVELS;
  localparam int TRAP_BASE = 1;
  localparam int TOP_SLOT  = 15;

  function automatic logic [VEC_W-1:0] lvl_vector(input logic [PRIO_W-1:0] lvl);
    return VEC_W'(TOP_SLOT) - VEC_W'(lvl);
  endfunction

  function automatic logic [VEC_W-1:0] trap_vector(input logic [2:0] idx);
    return VEC_W'(TRAP_BASE) + VEC_W'(idx);
  endfunction
endpackage

// File: rtl/irq_sample.sv
module irq_sample #(
  parameter int NUM_SRC  = 8,
  parameter int NUM_TRAP = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  flag_i,
  input  logic [NUM_TRAP-1:0] trap_i,
  output logic [NUM_SRC-1:0]  flag_q,
  output logic [NUM_TRAP-1:0] trap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      trap_q <= '0;
    end else begin
      flag_q <= flag_i;
      trap_q <= trap_i;
    end
  end
endmodule

// File: rtl/irq_rank.sv
module irq_rank
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_TRAP = 5,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int TRAP_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       flag_q,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [NUM_TRAP-1:0]      trap_q,
  output logic [LEVELS-1:0]        bus_q,
  output logic                     irq_hit_q,
  output logic [PRIO_W-1:0]        lvl_q,
  output logic [SRC_W-1:0]         src_q,
  output logic                     trap_hit_q,
  output logic [TRAP_W-1:0]        tidx_q
);
  logic [LEVELS-1:0] bus_d;
  logic              irq_hit_d;
  logic [PRIO_W-1:0] lvl_d;
  logic [SRC_W-1:0]  src_d;
  logic [TRAP_W-1:0] tidx_d;

  always_comb begin
    logic [PRIO_W-1:0] lv;
    bus_d     = '0;
    irq_hit_d = 1'b0;
    lvl_d     = '0;
    src_d     = '0;
    lv        = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      lv = prio_i[s*PRIO_W +: PRIO_W];
      if (flag_q[s]) begin
        bus_d[lv] = 1'b1;
        if (!irq_hit_d || lv > lvl_d) begin
          lvl_d = lv;
          src_d = SRC_W'(s);
        end
        irq_hit_d = 1'b1;
      end
    end
  end

  always_comb begin
    tidx_d = '0;
    for (int t = NUM_TRAP - 1; t >= 0; t--) begin
      if (trap_q[t]) tidx_d = TRAP_W'(t);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q      <= '0;
      irq_hit_q  <= 1'b0;
      lvl_q      <= '0;
      src_q      <= '0;
      trap_hit_q <= 1'b0;
      tidx_q     <= '0;
    end else begin
      bus_q      <= bus_d;
      irq_hit_q  <= irq_hit_d;
      lvl_q      <= lvl_d;
      src_q      <= src_d;
      trap_hit_q <= |trap_q;
      tidx_q     <= tidx_d;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  logic              irq_hit,
  input  logic [PRIO_W-1:0] lvl,
  input  logic              trap_hit,
  input  logic [2:0]        tidx,
  input  logic              gie,
  input  logic              nest_en,
  input  logic              busy,
  input  logic [LVL_W-1:0]  cpu_prio,
  output logic              take,
  output logic [VEC_W-1:0]  vec,
  output logic [LVL_W-1:0]  eff_lvl,
  output logic              above,
  output logic              allowed
);
  logic bypass;

  always_comb begin
    eff_lvl = trap_hit ? LVL_W'(TRAP_LVL) : {1'b0, lvl};
    above   = eff_lvl > cpu_prio;
    bypass  = trap_hit | (lvl == PRIO_W'(LEVELS - 1));
    allowed = bypass | (gie & (nest_en | ~busy));
    take    = (trap_hit | irq_hit) & above & allowed;
    vec     = trap_hit ? trap_vector(tidx) : lvl_vector(lvl);
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_TRAP = 5,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        flag_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [NUM_TRAP-1:0]       trap_i,
  input  logic                      gie_we_i,
  input  logic                      gie_d_i,
  input  logic                      nest_en_i,
  input  logic                      busy_i,
  input  logic [LVL_W-1:0]          cpu_prio_i,
  output logic [LEVELS-1:0]         irq_bus_o,
  output logic                      take_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [SRC_W-1:0]          src_o,
  output logic [LVL_W-1:0]          new_prio_o
);
  logic [NUM_SRC-1:0]  flag_q;
  logic [NUM_TRAP-1:0] trap_q;
  logic                irq_hit_q;
  logic [PRIO_W-1:0]   lvl_q;
  logic                trap_hit_q;
  logic [2:0]          tidx_q;
  logic                gie_q;
  logic                above_w;
  logic                allowed_w;

  always_ff @(posedge clk) begin
    if (!rst_n)        gie_q <= 1'b0;
    else if (gie_we_i) gie_q <= gie_d_i;
  end

  irq_sample #(.NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP)) u_sample (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .trap_i(trap_i),
    .flag_q(flag_q), .trap_q(trap_q)
  );

  irq_rank #(.NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP)) u_rank (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .prio_i(prio_i), .trap_q(trap_q),
    .bus_q(irq_bus_o), .irq_hit_q(irq_hit_q), .lvl_q(lvl_q), .src_q(src_o),
    .trap_hit_q(trap_hit_q), .tidx_q(tidx_q)
  );

  irq_gate u_gate (
    .irq_hit(irq_hit_q), .lvl(lvl_q), .trap_hit(trap_hit_q), .tidx(tidx_q),
    .gie(gie_q), .nest_en(nest_en_i), .busy(busy_i), .cpu_prio(cpu_prio_i),
    .take(take_o), .vec(vec_o), .eff_lvl(new_prio_o),
    .above(above_w), .allowed(allowed_w)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       take,
  input logic [3:0] new_prio,
  input logic [3:0] cpu_prio,
  input logic [3:0] vec,
  input logic [7:0] bus,
  input logic       gie_q,
  input logic       gie_we,
  input logic       busy,
  input logic       nest_en
);
  p_take_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (new_prio > cpu_prio));
  p_gie_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && new_prio < 4'd7) |-> gie_q);
  p_nest_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && new_prio < 4'd7 && busy) |-> nest_en);
  p_trap_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && new_prio == 4'd8) |-> (vec >= 4'd1 && vec <= 4'd5));
  p_lvl_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && new_prio < 4'd8) |-> (5'(vec) + 5'(new_prio) == 5'd15));
  p_bus_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus != 8'd0 && new_prio != 4'd8) |-> bus[new_prio[2:0]]);
  p_prio_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    new_prio <= 4'd8);
  p_gie_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gie_we) |-> (gie_q == $past(gie_q)));
endmodule

bind irq_arb irq_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take(take_o), .new_prio(new_prio_o),
  .cpu_prio(cpu_prio_i), .vec(vec_o), .bus(irq_bus_o), .gie_q(gie_q),
  .gie_we(gie_we_i), .busy(busy_i), .nest_en(nest_en_i)
);

// File: tb/irq_arb_test.sv
module irq_arb_test;
  localparam int NS = 8;
  localparam int NT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0]   flag_i = '0;
  logic [NS*3-1:0] prio_i = '0;
  logic [NT-1:0]   trap_i = '0;
  logic        gie_we_i = 1'b0, gie_d_i = 1'b0, nest_en_i = 1'b0, busy_i = 1'b0;
  logic [3:0]  cpu_prio_i = '0;
  logic [7:0]  irq_bus_o;
  logic        take_o;
  logic [3:0]  vec_o;
  logic [2:0]  src_o;
  logic [3:0]  new_prio_o;

  irq_arb uut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  bit auto_cpu = 0;

  // reference model state, as after the most recent clock edge
  bit m_f1 [NS];
  bit m_t1 [NT];
  int m_bus, m_lvl, m_src, m_tidx;
  bit m_hit, m_thit, m_gie;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NS; i++) m_f1[i] = 0;
    for (int i = 0; i < NT; i++) m_t1[i] = 0;
    m_bus = 0; m_lvl = 0; m_src = 0; m_tidx = 0; m_hit = 0; m_thit = 0; m_gie = 0;
  endtask

  task automatic model_edge();
    int p;
    m_bus = 0; m_hit = 0; m_lvl = 0; m_src = 0;
    for (int s = 0; s < NS; s++) begin
      p = int'(prio_i[s*3 +: 3]);
      if (m_f1[s]) begin
        m_bus = m_bus | (1 << p);
        if (!m_hit || p > m_lvl) begin m_lvl = p; m_src = s; end
        m_hit = 1;
      end
    end
    m_thit = 0; m_tidx = 0;
    for (int t = 0; t < NT; t++) if (m_t1[t] && !m_thit) begin m_thit = 1; m_tidx = t; end
    for (int s = 0; s < NS; s++) m_f1[s] = flag_i[s];
    for (int t = 0; t < NT; t++) m_t1[t] = trap_i[t];
    if (gie_we_i) m_gie = gie_d_i;
  endtask

  task automatic compare();
    int eff, evec;
    bit etake, open;
    string ttag;
    eff  = m_thit ? 8 : m_lvl;
    evec = m_thit ? 1 + m_tidx : 15 - m_lvl;
    open = m_thit || m_lvl == 7 || (m_gie && (nest_en_i || !busy_i));
    etake = (m_thit || m_hit) && (eff > int'(cpu_prio_i)) && open;
    if (m_thit || m_lvl == 7) ttag = "R5 take";
    else if (!m_gie) ttag = "R4 take";
    else if (busy_i && !nest_en_i) ttag = "R6 take";
    else ttag = "R3 take";
    chk("R2 irq_bus", int'(irq_bus_o), m_bus);
    chk(ttag, int'(take_o), int'(etake));
    chk("R7 vec", int'(vec_o), evec);
    chk("R9 new_prio", int'(new_prio_o), eff);
    if (m_hit && !m_thit) chk("R8 src", int'(src_o), m_src);
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
    if (auto_cpu) begin
      if (take_o) begin cpu_prio_i = new_prio_o; busy_i = 1'b1; end
      else if ($urandom_range(0, 9) == 0) begin cpu_prio_i = '0; busy_i = 1'b0; end
    end
    gie_we_i = 1'b0;
  endtask

  task automatic set_prio(input int s, input int p);
    prio_i[s*3 +: 3] = 3'(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state and R10: enable clear after reset
    @(negedge clk);
    chk("R10 reset bus", int'(irq_bus_o), 0);
    chk("R10 reset take", int'(take_o), 0);

    // R4/R10: level 3 pending, enable never written -> no take, bus tracks
    set_prio(2, 3); flag_i[2] = 1'b1;
    step(); step(); step();
    chk("R4 bus tracks", int'(irq_bus_o), 8);
    chk("R4 blocked", int'(take_o), 0);

    // R5: level 7 goes through with enable clear
    set_prio(5, 7); flag_i[5] = 1'b1;
    step(); step();
    chk("R5 level7 take", int'(take_o), 1);
    chk("R7 level7 slot", int'(vec_o), 8);

    // R1: priority changed between the two capture edges
    flag_i = '0; step(); step();
    set_prio(1, 2); flag_i[1] = 1'b1;
    step();                      // flag captured
    set_prio(1, 6);              // priority at the second edge counts
    step();
    chk("R1 late prio", int'(irq_bus_o), 8'h40);

    // R10: write enable, R8 tie at level 6 -> lowest source wins
    gie_d_i = 1'b1; gie_we_i = 1'b1;
    set_prio(4, 6); flag_i[4] = 1'b1;
    step(); step();
    chk("R8 tie src", int'(src_o), 1);
    chk("R10 enable write take", int'(take_o), 1);

    // R3: cpu at level 6 -> no take
    cpu_prio_i = 4'd6; step();
    chk("R3 equal level", int'(take_o), 0);

    // R6: busy with nesting off blocks; nesting on allows higher
    cpu_prio_i = 4'd2; busy_i = 1'b1; nest_en_i = 1'b0; step();
    chk("R6 no nest", int'(take_o), 0);
    nest_en_i = 1'b1; step();
    chk("R6 nest", int'(take_o), 1);

    // R7: traps ranked by index, above interrupts
    trap_i = 5'b10110; step(); step();
    chk("R7 trap slot", int'(vec_o), 2);
    chk("R9 trap level", int'(new_prio_o), 8);
    trap_i = 5'b10001; step(); step();
    chk("R7 osc trap slot", int'(vec_o), 1);
    cpu_prio_i = 4'd8; step();
    chk("R3 trap at 8", int'(take_o), 0);

    // R9: nothing pending
    trap_i = '0; flag_i = '0; step(); step();
    chk("R9 idle level", int'(new_prio_o), 0);
    chk("R9 idle slot", int'(vec_o), 15);

    // random traffic against the model
    cpu_prio_i = '0; busy_i = 1'b0; auto_cpu = 1;
    for (int n = 0; n < 4000; n++) begin
      flag_i = NS'($urandom);
      for (int s = 0; s < NS; s++) if ($urandom_range(0, 3) == 0) set_prio(s, $urandom_range(0, 7));
      trap_i = ($urandom_range(0, 15) == 0) ? NT'($urandom) : '0;
      if ($urandom_range(0, 7) == 0) begin gie_we_i = 1'b1; gie_d_i = 1'($urandom); end
      if ($urandom_range(0, 7) == 0) nest_en_i = 1'($urandom);
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule